// File: doc/BRIEF.md
# Processor Status Flags Register

This block is the byte-wide flag register of a CPU with a 16-bit accumulator. Two of its bits, zero and sign, are not stored. They are worked out at every moment from the live accumulator value. Three bits are stored and are updated from ALU result strobes:
- carry/borrow, from an add or subtract;
- overflow, from the carry out of the top two bits;
- equal, from a compare.

Two further stored bits are general-purpose flags that belong to software.

The ALU reports each cycle's operation class together with three event signals:
- the carry out of bit 14;
- the carry out of bit 15;
- the compare result.

Software writes the register over a byte bus with a write strobe. Each bit has its own access right. Zero, sign, overflow and the reserved bit cannot be changed by a write. Carry and equal can be written by software, but an ALU update in the same cycle takes priority. The read port always shows the current composed byte.

Top module: `sf_status_reg`

## Requirements
- R1: After any reset, all stored flags are 0, so with a zero accumulator the read port shows 0x80.
- R2: Bit 7 (zero) reads 1 exactly when the accumulator equals zero, in the same cycle, with no register delay.
- R3: Bit 6 (sign) always equals accumulator bit 15, in the same cycle.
- R4: When the operation class is arithmetic (code 2'b01), bit 2 (overflow) reads, from the next cycle, the XOR of carry-out-of-bit-14 and carry-out-of-bit-15.
- R5: When the operation class is arithmetic (code 2'b01), bit 1 (carry) reads, from the next cycle, the carry-out-of-bit-15 strobe, which also reports a borrow.
- R6: When the operation class is compare (code 2'b10), bit 0 (equal) reads the equality strobe from the next cycle.
- R7: A software write sets bits 4 and 3 (general flags) to the written data bits 4 and 3. The new values are readable from the next cycle.
- R8: With no ALU update to them, a software write loads bit 1 (carry) and bit 0 (equal) from the written data bits 1 and 0.
- R9: Bit 5 always reads 0.
- R10: Written data in bits 7, 6, 5 and 2 has no effect. In particular, overflow changes only through an arithmetic operation.
- R11: When an ALU update and a software write reach carry or equal in the same cycle, the ALU value is stored.
- R12: Flags that the current operation class does not update keep their value. Idle (2'b00) and the reserved code (2'b11) update no flag. Compare leaves carry and overflow unchanged. Arithmetic leaves equal unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears stored flags |
| acc_i | input | ACC_W | Live value of the active accumulator |
| alu_op_i | input | 2 | Operation class: 00 idle, 01 arithmetic, 10 compare, 11 reserved |
| alu_c14_i | input | 1 | Carry out of bit 14 for the current arithmetic operation |
| alu_c15_i | input | 1 | Carry or borrow out of bit 15 for the current arithmetic operation |
| alu_eq_i | input | 1 | Compare result, 1 for equal |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| rd_data_o | output | 8 | Composed flag byte |

## Verification
The bench builds the block with its default parameters: a 16-bit accumulator and two general flags. With these values the sign test sits on bit 15. This makes it possible to check the zero detector against values that have only the top bit set or only the bottom bit set. All four combinations of the two carry strobes are applied, so the overflow XOR is covered completely. Collisions between a software write and an ALU update are driven with the written value opposite to the ALU value. This way a wrong priority shows up at the read port.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int REG_W   = 8;
  localparam int Z_BIT   = 7;
  localparam int S_BIT   = 6;
  localparam int RSV_BIT = 5;
  localparam int GPF_LSB = 3;
  localparam int OV_BIT  = 2;
  localparam int C_BIT   = 1;
  localparam int E_BIT   = 0;

  typedef enum logic [1:0] {
    OPC_IDLE  = 2'b00,
    OPC_ARITH = 2'b01,
    OPC_CMP   = 2'b10,
    OPC_RSVD  = 2'b11
  } op_class_e;

  // Signed overflow: carries into and out of the top bit disagree.
  function automatic logic f_overflow(input logic c14, input logic c15);
    return c14 ^ c15;
  endfunction

  // Stored-flag next state with ALU priority over a software write.
  function automatic logic f_prio(input logic alu_hit, input logic alu_val,
                                  input logic sw_hit, input logic sw_val,
                                  input logic cur);
    if (alu_hit)     return alu_val;
    else if (sw_hit) return sw_val;
    else             return cur;
  endfunction
endpackage

// File: rtl/sf_acc_mirror.sv
module sf_acc_mirror #(
  parameter int ACC_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic             zero_o,
  output logic             sign_o
);
  localparam int MSB = ACC_W - 1;

  function automatic logic f_is_zero(input logic [ACC_W-1:0] v);
    logic any;
    any = 1'b0;
    for (int i = 0; i < ACC_W; i++) any = any | v[i];
    return ~any;
  endfunction

  assign zero_o = f_is_zero(acc_i);
  assign sign_o = acc_i[MSB];

  always_comb begin
    assert (zero_o == (acc_i == '0)) else $error("p_zero_mirror_r2");
  end
endmodule

// File: rtl/sf_alu_flags.sv
module sf_alu_flags
  import sf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  op_class_e op_i,
  input  logic      c14_i,
  input  logic      c15_i,
  input  logic      eq_i,
  input  logic      wr_en_i,
  input  logic      wr_c_i,
  input  logic      wr_e_i,
  output logic      c_o,
  output logic      ov_o,
  output logic      e_o
);
  logic arith_upd, cmp_upd;
  logic c_q, ov_q, e_q;
  logic c_d, ov_d, e_d;

  assign arith_upd = (op_i == OPC_ARITH);
  assign cmp_upd   = (op_i == OPC_CMP);

  assign c_d  = f_prio(arith_upd, c15_i, wr_en_i, wr_c_i, c_q);
  assign e_d  = f_prio(cmp_upd, eq_i, wr_en_i, wr_e_i, e_q);
  assign ov_d = arith_upd ? f_overflow(c14_i, c15_i) : ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q  <= 1'b0;
      ov_q <= 1'b0;
      e_q  <= 1'b0;
    end else begin
      c_q  <= c_d;
      ov_q <= ov_d;
      e_q  <= e_d;
    end
  end

  assign c_o  = c_q;
  assign ov_o = ov_q;
  assign e_o  = e_q;

  p_ov_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arith_upd |=> ov_q == ($past(c14_i) != $past(c15_i)));
  p_carry_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arith_upd |=> c_q == $past(c15_i));
  p_eq_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_upd |=> e_q == $past(eq_i));
  p_sw_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !arith_upd) |=> c_q == $past(wr_c_i));
  p_alu_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && cmp_upd && (wr_e_i != eq_i)) |=> e_q == $past(eq_i));
  p_cmp_keeps_carry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_upd && !wr_en_i) |=> $stable(c_q) && $stable(ov_q));
  p_arith_keeps_eq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_upd && !wr_en_i) |=> $stable(e_q));
endmodule

// File: rtl/sf_user_flags.sv
module sf_user_flags #(
  parameter int NUM_GPF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [NUM_GPF-1:0] wr_bits_i,
  output logic [NUM_GPF-1:0] gpf_o
);
  for (genvar g = 0; g < NUM_GPF; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (wr_en_i) q <= wr_bits_i[g];
    end
    assign gpf_o[g] = q;
  end

  p_gpf_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> gpf_o == $past(wr_bits_i));
  p_gpf_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(gpf_o));
endmodule

// File: rtl/sf_status_reg.sv
module sf_status_reg
  import sf_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int NUM_GPF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [1:0]       alu_op_i,
  input  logic             alu_c14_i,
  input  logic             alu_c15_i,
  input  logic             alu_eq_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o
);
  localparam int GPF_MSB = GPF_LSB + NUM_GPF - 1;

  op_class_e          op_cls;
  logic               zero_w, sign_w;
  logic               c_w, ov_w, e_w;
  logic [NUM_GPF-1:0] gpf_w;
  logic               ro_write_attempt;

  assign op_cls = op_class_e'(alu_op_i);
  assign ro_write_attempt = wr_en_i & (wr_data_i[Z_BIT] | wr_data_i[S_BIT] |
                                       wr_data_i[RSV_BIT] | wr_data_i[OV_BIT]);

  sf_acc_mirror #(.ACC_W(ACC_W)) u_mirror (
    .acc_i  (acc_i),
    .zero_o (zero_w),
    .sign_o (sign_w)
  );

  sf_alu_flags u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_cls),
    .c14_i   (alu_c14_i),
    .c15_i   (alu_c15_i),
    .eq_i    (alu_eq_i),
    .wr_en_i (wr_en_i),
    .wr_c_i  (wr_data_i[C_BIT]),
    .wr_e_i  (wr_data_i[E_BIT]),
    .c_o     (c_w),
    .ov_o    (ov_w),
    .e_o     (e_w)
  );

  sf_user_flags #(.NUM_GPF(NUM_GPF)) u_user (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_bits_i (wr_data_i[GPF_MSB:GPF_LSB]),
    .gpf_o     (gpf_w)
  );

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[Z_BIT]           = zero_w;
    rd_data_o[S_BIT]           = sign_w;
    rd_data_o[GPF_MSB:GPF_LSB] = gpf_w;
    rd_data_o[OV_BIT]          = ov_w;
    rd_data_o[C_BIT]           = c_w;
    rd_data_o[E_BIT]           = e_w;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (rd_data_o & 8'h3F) == 8'h00);
  p_sign_mirror_r3: assert property (@(posedge clk)
    rd_data_o[6] == acc_i[ACC_W-1]);
  p_rsvd_zero_r9: assert property (@(posedge clk)
    rd_data_o[5] == 1'b0);
  p_ro_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_write_attempt && op_cls != OPC_ARITH) |=> $stable(rd_data_o[2]));
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && (op_cls == OPC_IDLE || op_cls == OPC_RSVD))
      |=> $stable(rd_data_o[4:0]));
endmodule

// File: tb/tb_sf_status_reg.sv
module tb_sf_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] acc = '0;
  logic [1:0]  op = 2'b00;
  logic        c14 = 1'b0, c15 = 1'b0, eq = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model of stored flags
  logic m_c = 0, m_ov = 0, m_e = 0;
  logic [1:0] m_g = 0;

  always #4 clk = ~clk;

  sf_status_reg dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .alu_op_i(op),
    .alu_c14_i(c14), .alu_c15_i(c15), .alu_eq_i(eq),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd)
  );

  function automatic logic [7:0] expect_word(input logic [15:0] a);
    logic [7:0] w;
    w = 8'h00;
    if (a == 16'h0000) w = w | 8'h80;
    if (a >= 16'h8000) w = w | 8'h40;
    w = w | {3'b000, m_g, m_ov, m_c, m_e};
    return w;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clocked cycle: inputs already set at negedge; returns at next negedge idle
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    op = 2'b00; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; acc = 16'h0000;
    @(negedge clk); rst_n = 1'b1;
    m_c = 0; m_ov = 0; m_e = 0; m_g = 0;
    @(negedge clk);
    check("R1", rd, 8'h80);
  endtask

  task automatic t_mirror();
    logic [15:0] vals [5] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h7FFF};
    foreach (vals[i]) begin
      acc = vals[i]; #1;
      check("R2", rd & 8'h80, (vals[i] == 16'h0) ? 8'h80 : 8'h00);
      check("R3", rd & 8'h40, vals[i][15] ? 8'h40 : 8'h00);
    end
    acc = 16'h1234; #1;
  endtask

  task automatic t_arith();
    for (int k = 0; k < 4; k++) begin
      op = 2'b01; c14 = k[0]; c15 = k[1];
      cycle();
      m_ov = k[0] ^ k[1]; m_c = k[1];
      check("R4", rd & 8'h04, m_ov ? 8'h04 : 8'h00);
      check("R5", rd & 8'h02, m_c ? 8'h02 : 8'h00);
    end
  endtask

  task automatic t_compare();
    op = 2'b10; eq = 1'b1; cycle(); m_e = 1;
    check("R6", rd, expect_word(acc));
    op = 2'b10; eq = 1'b0; cycle(); m_e = 0;
    check("R6", rd, expect_word(acc));
  endtask

  task automatic t_gpf();
    wr_en = 1; wr_data = 8'h18; cycle(); m_g = 2'b11; m_c = 0; m_e = 0;
    check("R7", rd, expect_word(acc));
    wr_en = 1; wr_data = 8'h08; cycle(); m_g = 2'b01;
    check("R7", rd, expect_word(acc));
  endtask

  task automatic t_sw_ce();
    wr_en = 1; wr_data = 8'h0B; cycle(); m_c = 1; m_e = 1; m_g = 2'b01;
    check("R8", rd, expect_word(acc));
  endtask

  task automatic t_ro_ignored();
    // ov currently 1 from arith k=1? set it known first
    op = 2'b01; c14 = 1; c15 = 0; cycle(); m_ov = 1; m_c = 0;
    acc = 16'h0010;
    wr_en = 1; wr_data = 8'hE0 | {3'b0, m_g, 1'b0, m_c, m_e}; cycle();
    check("R10", rd, expect_word(acc));
    check("R9", rd & 8'h20, 8'h00);
    wr_en = 1; wr_data = 8'h04 | {3'b0, m_g, 1'b0, m_c, m_e}; cycle();
    check("R10", rd, expect_word(acc));
  endtask

  task automatic t_collision();
    op = 2'b01; c14 = 1; c15 = 1; wr_en = 1; wr_data = 8'h00; cycle();
    m_c = 1; m_ov = 0; m_g = 2'b00; m_e = 0;
    check("R11", rd, expect_word(acc));
    wr_en = 1; wr_data = 8'h01; cycle(); m_e = 1; m_c = 0;
    op = 2'b10; eq = 0; wr_en = 1; wr_data = 8'h01; cycle();
    m_e = 0; m_c = 0;
    check("R11", rd, expect_word(acc));
  endtask

  task automatic t_hold();
    wr_en = 1; wr_data = 8'h1B; cycle(); m_g = 2'b11; m_c = 1; m_e = 1;
    op = 2'b01; c14 = 1; c15 = 0; cycle(); m_c = 0; m_ov = 1;
    op = 2'b10; eq = 0; cycle(); m_e = 0;
    check("R12", rd, expect_word(acc));
    op = 2'b11; c14 = 0; c15 = 1; eq = 1; cycle();
    check("R12", rd, expect_word(acc));
    op = 2'b00; cycle();
    check("R12", rd, expect_word(acc));
    op = 2'b01; c14 = 0; c15 = 0; eq = 1; cycle(); m_c = 0; m_ov = 0;
    check("R12", rd, expect_word(acc));
  endtask

  initial begin
    t_reset();
    t_mirror();
    t_arith();
    t_compare();
    t_gpf();
    t_sw_ce();
    t_ro_ignored();
    t_collision();
    t_hold();
    acc = 16'h0000;
    t_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule